// File: doc/BRIEF.md
# Paged Memory Access Controller

This block sits behind a byte-oriented serial-bus target and turns its transaction events into accesses to a 2048-byte space made of eight 256-byte pages. The target reports the start of a transaction together with an 8-bit address, then issues data-byte write strobes or data-byte read requests, and finally the end of the transaction. The block holds a 3-bit page register and an in-page offset that advances after every data byte. Page 0 holds a small bank of control registers. Pages 1 to 7 hold waveform RAM.

Offset 0xFF of every page is also the address of the page register. The kind of transaction decides which one is reached. A transaction that begins at 0xFF loads the page register from its first data byte. A multi-byte write that begins lower and runs onto 0xFF stores that byte into memory. Writes carry on into the next page when they pass the end of a page. Reads stay on their page and wrap around to offset 0x00.

Top module: `pgmem_ctrl`

## Requirements
- R1: After reset the page register is 0, `rd_valid` is low and every control register reads 0x00. The RAM contents are kept through a reset.
- R2: In a transaction whose start address is 0xFF, the first written data byte loads the page register from its bits [2:0]. Its bits [7:3] are ignored.
- R3: In a transaction whose start address is 0xFF, every data byte after the first is discarded. Neither the page register nor any memory byte changes.
- R4: A write transaction that starts below 0xFF and advances onto offset 0xFF stores that byte into memory at offset 0xFF of the current page.
- R5: A write at offset 0xFF increments the page register and wraps the offset to 0x00, so the next byte lands on the following page. From page 7 the page wraps to 0, which is the control bank.
- R6: A read at offset 0xFF wraps the offset to 0x00 of the same page. Reads never change the page register.
- R7: On page 0, offsets 0x00 to 0x0B are read/write control registers whose values also appear on `ctrl_regs`, register n on bits [8n+7:8n]. Other page-0 offsets read 0x00, and writes to them are ignored.
- R8: Pages 1 to 7 are independent RAM pages. A byte written at a given page and offset reads back only from that page and offset.
- R9: A read request accepted in a transaction returns its byte on `rd_data` with `rd_valid` high for exactly one cycle, on the clock edge after the request.
- R10: Write strobes and read requests outside a transaction (after `txn_end` and before the next `txn_start`) are ignored. They change no storage and raise no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start | input | 1 | Start of transaction; latches `txn_addr` as the offset |
| txn_addr | input | 8 | Start address of the transaction |
| wr_stb | input | 1 | One data byte to write |
| wr_data | input | 8 | Write data byte |
| rd_req | input | 1 | Request for one data byte |
| txn_end | input | 1 | End of transaction |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | `rd_data` holds the requested byte |
| page | output | 3 | Current page register |
| ctrl_regs | output | 96 | Control register bank, flattened |

## Verification
The bench builds the block with its default parameters: a 3-bit page, an 8-bit offset, 8-bit data and twelve control registers. With these values the boundary cases are reachable in a few bytes each: the shared 0xFF offset, the step from one page to the next, and the wrap from page 7 back into the control bank. The twelve-register bank places both the last implemented offset (0x0B) and the first unimplemented one (0x0C) inside a single three-byte burst. The full 1792-byte RAM is elaborated, so page independence is checked on real storage rather than on a reduced model.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;
   // destination of a data-byte access
   typedef enum logic {
      DST_CTRL = 1'b0,
      DST_RAM  = 1'b1
   } dst_e;
endpackage

// File: rtl/pgmem_cursor.sv
// Tracks page register, in-page offset and transaction state.
module pgmem_cursor #(
   parameter int PAGE_W = 3,
   parameter int OFS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic [OFS_W-1:0]  txn_addr,
   input  logic              wr_stb,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic              rd_req,
   input  logic              txn_end,
   output logic [PAGE_W-1:0] page_q,
   output logic [OFS_W-1:0]  ofs_q,
   output logic              active_q,
   output logic              sel_mode_q,
   output logic              sel_used_q,
   output logic              acc_wr,
   output logic              acc_rd
);
   logic wr_ev, rd_ev;

   assign wr_ev  = active_q && !txn_start && !txn_end && wr_stb;
   assign rd_ev  = active_q && !txn_start && !txn_end && !wr_stb && rd_req;
   assign acc_wr = wr_ev && !sel_mode_q;
   assign acc_rd = rd_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q     <= '0;
         ofs_q      <= '0;
         active_q   <= 1'b0;
         sel_mode_q <= 1'b0;
         sel_used_q <= 1'b0;
      end else if (txn_start) begin
         active_q   <= 1'b1;
         ofs_q      <= txn_addr;
         sel_mode_q <= &txn_addr;
         sel_used_q <= 1'b0;
      end else if (txn_end) begin
         active_q   <= 1'b0;
         sel_mode_q <= 1'b0;
         sel_used_q <= 1'b0;
      end else if (wr_ev) begin
         if (sel_mode_q) begin
            if (!sel_used_q) begin
               page_q     <= wr_page;
               sel_used_q <= 1'b1;
            end
         end else begin
            ofs_q <= ofs_q + OFS_W'(1);
            if (&ofs_q) begin
               page_q <= page_q + PAGE_W'(1);
            end
         end
      end else if (rd_ev) begin
         ofs_q <= ofs_q + OFS_W'(1);
      end
   end
endmodule

// File: rtl/pgmem_regbank.sv
// Control register bank on page 0.
module pgmem_regbank #(
   parameter int DATA_W   = 8,
   parameter int OFS_W    = 8,
   parameter int NUM_REGS = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [OFS_W-1:0]           waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [OFS_W-1:0]           raddr,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   logic [DATA_W-1:0] regs [NUM_REGS];

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[gi] <= '0;
         end else if (we && (waddr == OFS_W'(gi))) begin
            regs[gi] <= wdata;
         end
      end
      assign regs_flat[gi*DATA_W +: DATA_W] = regs[gi];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (raddr == OFS_W'(i)) begin
            rdata = regs[i];
         end
      end
   end
endmodule

// File: rtl/pgmem_store.sv
// Waveform RAM: one write port, one registered read port, no reset.
module pgmem_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1792,
   parameter int AW     = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      if (re) begin
         q <= mem[raddr];
      end
   end
endmodule

// File: rtl/pgmem_ctrl.sv
// Top: paged access controller for control bank plus waveform RAM.
module pgmem_ctrl #(
   parameter int PAGE_W   = 3,
   parameter int OFS_W    = 8,
   parameter int DATA_W   = 8,
   parameter int NUM_CTRL = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       txn_start,
   input  logic [OFS_W-1:0]           txn_addr,
   input  logic                       wr_stb,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       rd_req,
   input  logic                       txn_end,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       rd_valid,
   output logic [PAGE_W-1:0]          page,
   output logic [NUM_CTRL*DATA_W-1:0] ctrl_regs
);
   import pgmem_pkg::*;

   localparam int NUM_PAGES  = 1 << PAGE_W;
   localparam int PAGE_BYTES = 1 << OFS_W;
   localparam int RAM_PAGES  = NUM_PAGES - 1;
   localparam int RAM_DEPTH  = RAM_PAGES * PAGE_BYTES;
   localparam int RAM_AW     = PAGE_W + OFS_W;

   if (PAGE_W < 1) begin : g_chk_pw
      $error("PAGE_W must be at least 1");
   end
   if (PAGE_W > DATA_W) begin : g_chk_pd
      $error("PAGE_W must fit in one data byte");
   end
   if (NUM_CTRL < 1 || NUM_CTRL > PAGE_BYTES) begin : g_chk_nc
      $error("NUM_CTRL must lie within one page");
   end

   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;
   logic              active_q, sel_mode_q, sel_used_q;
   logic              acc_wr, acc_rd;

   pgmem_cursor #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .txn_start  (txn_start),
      .txn_addr   (txn_addr),
      .wr_stb     (wr_stb),
      .wr_page    (wr_data[PAGE_W-1:0]),
      .rd_req     (rd_req),
      .txn_end    (txn_end),
      .page_q     (page_q),
      .ofs_q      (ofs_q),
      .active_q   (active_q),
      .sel_mode_q (sel_mode_q),
      .sel_used_q (sel_used_q),
      .acc_wr     (acc_wr),
      .acc_rd     (acc_rd)
   );

   dst_e              dst;
   logic [PAGE_W-1:0] ram_page;
   logic [RAM_AW-1:0] ram_idx;

   assign dst      = (page_q != '0) ? DST_RAM : DST_CTRL;
   assign ram_page = page_q - PAGE_W'(1);
   assign ram_idx  = {ram_page, ofs_q};

   logic [DATA_W-1:0] ctrl_rdata, ram_q;

   pgmem_regbank #(.DATA_W(DATA_W), .OFS_W(OFS_W), .NUM_REGS(NUM_CTRL)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (acc_wr && dst == DST_CTRL),
      .waddr     (ofs_q),
      .wdata     (wr_data),
      .raddr     (ofs_q),
      .rdata     (ctrl_rdata),
      .regs_flat (ctrl_regs)
   );

   pgmem_store #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
      .clk   (clk),
      .we    (acc_wr && dst == DST_RAM),
      .waddr (ram_idx),
      .wdata (wr_data),
      .re    (acc_rd && dst == DST_RAM),
      .raddr (ram_idx),
      .q     (ram_q)
   );

   logic              rd_valid_q;
   dst_e              rd_dst_q;
   logic [DATA_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_dst_q   <= DST_CTRL;
         ctrl_q     <= '0;
      end else begin
         rd_valid_q <= acc_rd;
         if (acc_rd) begin
            rd_dst_q <= dst;
            ctrl_q   <= ctrl_rdata;
         end
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = (rd_dst_q == DST_RAM) ? ram_q : ctrl_q;
   assign page     = page_q;
endmodule

// File: rtl/pgmem_ctrl_chk.sv
module pgmem_ctrl_chk #(
   parameter int PAGE_W = 3,
   parameter int OFS_W  = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              txn_start,
   input logic              txn_end,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_valid,
   input logic [PAGE_W-1:0] page,
   input logic [OFS_W-1:0]  ofs_q,
   input logic              active_q,
   input logic              sel_mode_q,
   input logic              sel_used_q,
   input logic              acc_wr,
   input logic              acc_rd
);
   AST_PAGE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> page == '0); // R1
   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && sel_mode_q && !sel_used_q && wr_stb && !txn_start && !txn_end)
      |=> page == $past(wr_data[PAGE_W-1:0])); // R2
   AST_SEL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      sel_mode_q |-> !acc_wr); // R3
   AST_SEL_EXTRA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && sel_mode_q && sel_used_q && wr_stb && !txn_start && !txn_end)
      |=> $stable(page)); // R3
   AST_WR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && &ofs_q) |=> page == $past(page) + PAGE_W'(1)); // R5
   AST_RD_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> $stable(page)); // R6
   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> rd_valid); // R9
   AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(acc_rd)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (!acc_wr && !acc_rd)); // R10
endmodule

bind pgmem_ctrl pgmem_ctrl_chk #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .txn_start  (txn_start),
   .txn_end    (txn_end),
   .wr_data    (wr_data),
   .rd_valid   (rd_valid),
   .page       (page),
   .ofs_q      (ofs_q),
   .active_q   (active_q),
   .sel_mode_q (sel_mode_q),
   .sel_used_q (sel_used_q),
   .acc_wr     (acc_wr),
   .acc_rd     (acc_rd)
);

// File: tb/pgmem_ctrl_bench.sv
module pgmem_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        txn_start = 1'b0;
   logic [7:0]  txn_addr = '0;
   logic        wr_stb = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_req = 1'b0;
   logic        txn_end = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [2:0]  page;
   logic [95:0] ctrl_regs;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   pgmem_ctrl u_pgmem_ctrl (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_req(rd_req), .txn_end(txn_end),
      .rd_data(rd_data), .rd_valid(rd_valid), .page(page), .ctrl_regs(ctrl_regs)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // all helpers begin and end at a falling edge
   task automatic begin_txn(input logic [7:0] a);
      txn_start = 1'b1; txn_addr = a;
      @(negedge clk); txn_start = 1'b0;
   endtask
   task automatic end_txn();
      txn_end = 1'b1;
      @(negedge clk); txn_end = 1'b0;
   endtask
   task automatic wbyte(input logic [7:0] d);
      wr_stb = 1'b1; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask
   task automatic rbyte(input logic [7:0] exp, input string req);
      rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      chk(rd_valid === 1'b1, req, "rd_valid", int'(rd_valid), 1);
      chk(rd_data === exp, req, "rd_data", int'(rd_data), int'(exp));
   endtask
   task automatic set_page(input logic [7:0] p);
      begin_txn(8'hFF); wbyte(p); end_txn();
   endtask

   task automatic t_reset();
      chk(page === 3'd0, "R1", "page after reset", int'(page), 0);
      chk(rd_valid === 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
      chk(ctrl_regs === '0, "R1", "ctrl regs after reset", int'(ctrl_regs[31:0]), 0);
   endtask

   task automatic t_page_select();
      set_page(8'hFD);
      chk(page === 3'd5, "R2", "page from 0xFD", int'(page), 5);
      begin_txn(8'h00); wbyte(8'h55); end_txn();
      begin_txn(8'hFF); wbyte(8'h0A); wbyte(8'h03); wbyte(8'h07); end_txn();
      chk(page === 3'd2, "R3", "page after extra bytes", int'(page), 2);
      set_page(8'h05);
      begin_txn(8'h00); rbyte(8'h55, "R3"); end_txn();
   endtask

   task automatic t_top_byte();
      begin_txn(8'hFE); wbyte(8'hA1); wbyte(8'hB2); wbyte(8'hC3); end_txn();
      chk(page === 3'd6, "R5", "page after crossing", int'(page), 6);
      set_page(8'h05);
      begin_txn(8'hFE);
      rbyte(8'hA1, "R4");
      rbyte(8'hB2, "R4");
      rbyte(8'h55, "R6");
      end_txn();
      chk(page === 3'd5, "R6", "page after read wrap", int'(page), 5);
      set_page(8'h06);
      begin_txn(8'h00); rbyte(8'hC3, "R5"); end_txn();
      @(negedge clk);
      chk(rd_valid === 1'b0, "R9", "rd_valid single cycle", int'(rd_valid), 0);
   endtask

   task automatic t_wrap7();
      set_page(8'h07);
      begin_txn(8'hFE); wbyte(8'h11); wbyte(8'h22); wbyte(8'h9A); end_txn();
      chk(page === 3'd0, "R5", "page wrap 7->0", int'(page), 0);
      chk(ctrl_regs[7:0] === 8'h9A, "R5", "ctrl reg0 after wrap", int'(ctrl_regs[7:0]), 'h9A);
      set_page(8'h07);
      begin_txn(8'hFE); rbyte(8'h11, "R5"); rbyte(8'h22, "R5"); end_txn();
   endtask

   task automatic t_ctrl_bank();
      set_page(8'h00);
      begin_txn(8'h0A); wbyte(8'h12); wbyte(8'h34); wbyte(8'h56); end_txn();
      chk(ctrl_regs[87:80] === 8'h12, "R7", "ctrl reg 0x0A", int'(ctrl_regs[87:80]), 'h12);
      chk(ctrl_regs[95:88] === 8'h34, "R7", "ctrl reg 0x0B", int'(ctrl_regs[95:88]), 'h34);
      begin_txn(8'h0A);
      rbyte(8'h12, "R7"); rbyte(8'h34, "R7"); rbyte(8'h00, "R7");
      end_txn();
      begin_txn(8'hC0); rbyte(8'h00, "R7"); end_txn();
   endtask

   task automatic t_pages();
      set_page(8'h01); begin_txn(8'h10); wbyte(8'h71); end_txn();
      set_page(8'h02); begin_txn(8'h10); wbyte(8'h72); end_txn();
      set_page(8'h01); begin_txn(8'h10); rbyte(8'h71, "R8"); end_txn();
      set_page(8'h02); begin_txn(8'h10); rbyte(8'h72, "R8"); end_txn();
   endtask

   task automatic t_idle();
      set_page(8'h00);
      begin_txn(8'h03); end_txn();
      wbyte(8'hEE);
      rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      chk(rd_valid === 1'b0, "R10", "rd_valid outside txn", int'(rd_valid), 0);
      chk(ctrl_regs[31:24] === 8'h00, "R10", "ctrl reg3 untouched", int'(ctrl_regs[31:24]), 0);
      chk(page === 3'd0, "R10", "page untouched", int'(page), 0);
   endtask

   task automatic t_persist();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(page === 3'd0, "R1", "page after second reset", int'(page), 0);
      chk(ctrl_regs[7:0] === 8'h00, "R1", "ctrl reg0 cleared", int'(ctrl_regs[7:0]), 0);
      set_page(8'h01);
      begin_txn(8'h10); rbyte(8'h71, "R1"); end_txn();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_page_select();
      t_top_byte();
      t_wrap7();
      t_ctrl_bank();
      t_pages();
      t_idle();
      t_persist();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule